// File: doc/BRIEF.md
# Grouped AND-OR Bus Selector with Exclusivity Checking

The block drives one registered output bus from several data sources. Each source has its own enable line. The sources are split into fixed-size groups. Inside a group the enabled words are combined with a flat AND-OR, with no priority between members: every active enable contributes its word. Between groups there is a strict order. The lowest-numbered group that has any active enable supplies the next bus value, and the later groups are ignored in that cycle. When no enable is high anywhere, the register keeps its value.

Alongside the datapath, each group has an exclusivity monitor. A two-bit mode per group selects the rule: no check, at most one active enable, at least one active enable, or exactly one. A global check-enable input gates all of the monitors. Each group reports a combinational per-cycle violation flag. Each group also has a two-state tracker (CLEAN, LATCHED) that moves from CLEAN to LATCHED on the first violation and returns to CLEAN only on reset. A violation never changes the datapath: the bus still takes the OR of every active word in the winning group, so the hardware result stays defined.

Top module: `mbs_bus_sel`

## Requirements
- R1: An asynchronous active-high reset clears `bus_q` to all zeros and puts every group's tracker in CLEAN (`viol_sticky` all zeros).
- R2: When a group wins, the next `bus_q` equals the bitwise OR of every enabled word in that group, one edge after the enables are applied. This holds when several enables of the group are high at once.
- R3: When every bit of `src_en` is low, `bus_q` keeps its previous value across the edge.
- R4: When any enable of a lower-numbered group is high, that group's result is loaded. Enables and data of higher-numbered groups have no effect on `bus_q`.
- R5: When only a higher-numbered group has active enables, `bus_q` loads that group's AND-OR result.
- R6: With `chk_en` high and group mode 01 (at most one), `viol_now[g]` is high in the same cycle exactly when two or more of that group's enables are high.
- R7: With `chk_en` high and group mode 10 (at least one), `viol_now[g]` is high in the same cycle exactly when none of that group's enables are high.
- R8: With `chk_en` high and group mode 11 (exactly one), `viol_now[g]` is high in the same cycle exactly when the count of that group's active enables is not one.
- R9: With group mode 00, or with `chk_en` low, `viol_now[g]` is low whatever the enables are.
- R10: After any cycle in which `viol_now[g]` is high, `viol_sticky[g]` is high from the next edge onward until reset.
- R11: Group g takes its enables from `src_en[g*GRP_SIZE +: GRP_SIZE]` and its data from the matching `DATA_W`-bit slices of `src_data` (source i at bits `i*DATA_W +: DATA_W`). Its mode comes from `chk_mode[2*g +: 2]`. Modes of different groups act independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset |
| src_en | input | NUM_GRP*GRP_SIZE | One enable per source, grouped consecutively |
| src_data | input | NUM_GRP*GRP_SIZE*DATA_W | Packed source words, source i at bits i*DATA_W |
| chk_en | input | 1 | Global gate for the exclusivity monitors |
| chk_mode | input | 2*NUM_GRP | Per-group rule: 00 off, 01 at most one, 10 at least one, 11 exactly one |
| bus_q | output | DATA_W | Registered selected bus |
| viol_now | output | NUM_GRP | Per-group violation in the current cycle |
| viol_sticky | output | NUM_GRP | Per-group latched violation, cleared only by reset |

## Verification
Two things can happen in the same cycle: an illegal multi-hot pattern inside the winning group updates the bus, and that group's monitor reports the violation. The bench provokes this with two-hot codes inside group 0 and inside group 1 under each mode. It checks the combined word in `bus_q` after the edge, `viol_now` before the edge, and the tracker's change to LATCHED on the following edge. A second overlap is group precedence together with a violation in the losing group. The bench checks that the loser's flag still rises while its data stays off the bus.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    // Per-group exclusivity rule, 2-bit field per group.
    typedef enum logic [1:0] {
        CHK_OFF      = 2'b00,
        CHK_AT_MOST  = 2'b01,
        CHK_AT_LEAST = 2'b10,
        CHK_EXACT    = 2'b11
    } chk_mode_e;

    // Violation tracker states.
    typedef enum logic {
        TRK_CLEAN   = 1'b0,
        TRK_LATCHED = 1'b1
    } trk_state_e;

endpackage

// File: rtl/mbs_group_or.sv
module mbs_group_or #(
    parameter int DATA_W   = 64,
    parameter int GRP_SIZE = 3
) (
    input  logic [GRP_SIZE-1:0]        en,
    input  logic [GRP_SIZE*DATA_W-1:0] data,
    output logic [DATA_W-1:0]          word,
    output logic                       any
);

    logic [DATA_W-1:0] gated [GRP_SIZE];

    // Each member masks its own word; no member outranks another.
    for (genvar i = 0; i < GRP_SIZE; i++) begin : g_gate
        assign gated[i] = data[i*DATA_W +: DATA_W] & {DATA_W{en[i]}};
    end

    always_comb begin
        word = '0;
        for (int i = 0; i < GRP_SIZE; i++) begin
            word = word | gated[i];
        end
    end

    assign any = |en;

endmodule

// File: rtl/mbs_group_chk.sv
module mbs_group_chk
    import mbs_pkg::*;
#(
    parameter int GRP_SIZE = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [GRP_SIZE-1:0] en,
    input  logic                chk_en,
    input  logic [1:0]          mode,
    output logic                viol_now,
    output logic                viol_sticky
);

    localparam int CNT_W = $clog2(GRP_SIZE + 1);

    logic [CNT_W-1:0] hot_cnt;
    logic             too_many;
    logic             none_hot;
    chk_mode_e        rule;
    trk_state_e       state_q, state_d;

    always_comb begin
        hot_cnt = '0;
        for (int i = 0; i < GRP_SIZE; i++) begin
            hot_cnt = hot_cnt + CNT_W'(en[i]);
        end
    end

    assign too_many = (hot_cnt > CNT_W'(1));
    assign none_hot = (hot_cnt == '0);
    assign rule     = chk_mode_e'(mode);

    always_comb begin
        viol_now = 1'b0;
        if (chk_en) begin
            unique case (rule)
                CHK_OFF:      viol_now = 1'b0;
                CHK_AT_MOST:  viol_now = too_many;
                CHK_AT_LEAST: viol_now = none_hot;
                CHK_EXACT:    viol_now = too_many | none_hot;
                default:      viol_now = 1'b0;
            endcase
        end
    end

    // Tracker state register.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= TRK_CLEAN;
        end else begin
            state_q <= state_d;
        end
    end

    // Tracker transitions: CLEAN -> LATCHED on violation, LATCHED holds.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_CLEAN:   state_d = viol_now ? TRK_LATCHED : TRK_CLEAN;
            TRK_LATCHED: state_d = TRK_LATCHED;
            default:     state_d = TRK_CLEAN;
        endcase
    end

    // Tracker outputs.
    always_comb begin
        unique case (state_q)
            TRK_CLEAN:   viol_sticky = 1'b0;
            TRK_LATCHED: viol_sticky = 1'b1;
            default:     viol_sticky = 1'b0;
        endcase
    end

endmodule

// File: rtl/mbs_bus_sel.sv
module mbs_bus_sel #(
    parameter int DATA_W   = 64,
    parameter int GRP_SIZE = 3,
    parameter int NUM_GRP  = 2
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [NUM_GRP*GRP_SIZE-1:0]          src_en,
    input  logic [NUM_GRP*GRP_SIZE*DATA_W-1:0]   src_data,
    input  logic                                 chk_en,
    input  logic [2*NUM_GRP-1:0]                 chk_mode,
    output logic [DATA_W-1:0]                    bus_q,
    output logic [NUM_GRP-1:0]                   viol_now,
    output logic [NUM_GRP-1:0]                   viol_sticky
);

    localparam int GRP_BITS = GRP_SIZE * DATA_W;

    logic [DATA_W-1:0] grp_word [NUM_GRP];
    logic [NUM_GRP-1:0] grp_any;
    logic [DATA_W-1:0] bus_d;
    logic              load;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        mbs_group_or #(
            .DATA_W   (DATA_W),
            .GRP_SIZE (GRP_SIZE)
        ) u_or (
            .en   (src_en[g*GRP_SIZE +: GRP_SIZE]),
            .data (src_data[g*GRP_BITS +: GRP_BITS]),
            .word (grp_word[g]),
            .any  (grp_any[g])
        );

        mbs_group_chk #(
            .GRP_SIZE (GRP_SIZE)
        ) u_chk (
            .clk         (clk),
            .rst         (rst),
            .en          (src_en[g*GRP_SIZE +: GRP_SIZE]),
            .chk_en      (chk_en),
            .mode        (chk_mode[2*g +: 2]),
            .viol_now    (viol_now[g]),
            .viol_sticky (viol_sticky[g])
        );
    end

    // Group precedence: scan from the last group down so the lowest active wins.
    always_comb begin
        bus_d = '0;
        for (int g = NUM_GRP - 1; g >= 0; g--) begin
            if (grp_any[g]) begin
                bus_d = grp_word[g];
            end
        end
    end

    assign load = |grp_any;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            bus_q <= '0;
        end else if (load) begin
            bus_q <= bus_d;
        end
    end

endmodule

// File: rtl/mbs_sva.sv
module mbs_sva #(
    parameter int DATA_W   = 64,
    parameter int GRP_SIZE = 3,
    parameter int NUM_GRP  = 2
) (
    input logic                               clk,
    input logic                               rst,
    input logic [NUM_GRP*GRP_SIZE-1:0]        src_en,
    input logic [NUM_GRP*GRP_SIZE*DATA_W-1:0] src_data,
    input logic                               chk_en,
    input logic [2*NUM_GRP-1:0]               chk_mode,
    input logic [DATA_W-1:0]                  bus_q,
    input logic [NUM_GRP-1:0]                 viol_now,
    input logic [NUM_GRP-1:0]                 viol_sticky
);

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (src_en == '0) |=> $stable(bus_q));

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_prop
        assert_multi_hot_R6: assert property (@(posedge clk) disable iff (rst)
            (chk_en && chk_mode[2*g +: 2] == 2'b01 &&
             $countones(src_en[g*GRP_SIZE +: GRP_SIZE]) > 1) |-> viol_now[g]);

        assert_none_hot_R7: assert property (@(posedge clk) disable iff (rst)
            (chk_en && chk_mode[2*g +: 2] == 2'b10 &&
             src_en[g*GRP_SIZE +: GRP_SIZE] == '0) |-> viol_now[g]);

        assert_exact_R8: assert property (@(posedge clk) disable iff (rst)
            (chk_en && chk_mode[2*g +: 2] == 2'b11) |->
            (viol_now[g] == ($countones(src_en[g*GRP_SIZE +: GRP_SIZE]) != 1)));

        assert_quiet_off_R9: assert property (@(posedge clk) disable iff (rst)
            (!chk_en || chk_mode[2*g +: 2] == 2'b00) |-> !viol_now[g]);

        assert_sticky_set_R10: assert property (@(posedge clk) disable iff (rst)
            viol_now[g] |=> viol_sticky[g]);

        assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (rst)
            viol_sticky[g] |=> viol_sticky[g]);
    end

endmodule

bind mbs_bus_sel mbs_sva #(
    .DATA_W   (DATA_W),
    .GRP_SIZE (GRP_SIZE),
    .NUM_GRP  (NUM_GRP)
) u_sva (
    .clk         (clk),
    .rst         (rst),
    .src_en      (src_en),
    .src_data    (src_data),
    .chk_en      (chk_en),
    .chk_mode    (chk_mode),
    .bus_q       (bus_q),
    .viol_now    (viol_now),
    .viol_sticky (viol_sticky)
);

// File: tb/mbs_bus_sel_bench.sv
`timescale 1ns/1ps
module mbs_bus_sel_bench;

    localparam int DW = 64;
    localparam int GS = 3;
    localparam int NG = 2;
    localparam int NS = GS * NG;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NS-1:0]     src_en = '0;
    logic [NS*DW-1:0]  src_data = '0;
    logic              chk_en = 1'b0;
    logic [2*NG-1:0]   chk_mode = '0;
    logic [DW-1:0]     bus_q;
    logic [NG-1:0]     viol_now;
    logic [NG-1:0]     viol_sticky;

    mbs_bus_sel #(.DATA_W(DW), .GRP_SIZE(GS), .NUM_GRP(NG)) u_mbs_bus_sel (
        .clk(clk), .rst(rst), .src_en(src_en), .src_data(src_data),
        .chk_en(chk_en), .chk_mode(chk_mode), .bus_q(bus_q),
        .viol_now(viol_now), .viol_sticky(viol_sticky)
    );

    always #4 clk = ~clk;  // 125 MHz

    typedef struct {
        logic [DW-1:0] bus;
        logic [NG-1:0] sticky;
        string         tag;
    } item_t;

    item_t         sb_q [$];
    logic [DW-1:0] words [NS];
    logic [DW-1:0] exp_bus = '0;
    logic [NG-1:0] exp_sticky = '0;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic pack_words();
        for (int i = 0; i < NS; i++) src_data[i*DW +: DW] = words[i];
    endtask

    // Reference: lowest group with an active enable wins, AND-OR inside it.
    function automatic logic [DW-1:0] ref_bus(input logic [NS-1:0] en, input logic [DW-1:0] prev);
        for (int g = 0; g < NG; g++) begin
            logic [DW-1:0] acc = '0;
            bit hit = 0;
            for (int i = 0; i < GS; i++) begin
                if (en[g*GS+i]) begin
                    acc = acc | words[g*GS+i];
                    hit = 1;
                end
            end
            if (hit) return acc;
        end
        return prev;
    endfunction

    function automatic logic [NG-1:0] ref_viol(input logic [NS-1:0] en, input logic [2*NG-1:0] md, input logic ce);
        logic [NG-1:0] v = '0;
        for (int g = 0; g < NG; g++) begin
            int cnt = 0;
            for (int i = 0; i < GS; i++) cnt += int'(en[g*GS+i]);
            if (ce) begin
                case (md[2*g +: 2])
                    2'b01: v[g] = (cnt > 1);
                    2'b10: v[g] = (cnt == 0);
                    2'b11: v[g] = (cnt != 1);
                    default: v[g] = 1'b0;
                endcase
            end
        end
        return v;
    endfunction

    // Driver: applies one cycle of stimulus, checks the same-cycle flags,
    // pushes the post-edge expectation into the scoreboard.
    task automatic apply(input logic [NS-1:0] en, input logic [2*NG-1:0] md,
                         input logic ce, input string tag);
        logic [NG-1:0] ev;
        item_t it;
        @(negedge clk);
        src_en = en; chk_mode = md; chk_en = ce;
        pack_words();
        #1;
        ev = ref_viol(en, md, ce);
        check({tag, " viol_now"}, DW'(viol_now), DW'(ev));
        exp_bus = ref_bus(en, exp_bus);
        exp_sticky = exp_sticky | ev;
        it.bus = exp_bus; it.sticky = exp_sticky; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: after each rising edge, compare against the next expected item.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check({it.tag, " bus_q"}, bus_q, it.bus);
                check({it.tag, " viol_sticky"}, DW'(viol_sticky), DW'(it.sticky));
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; src_en = '0; chk_en = 1'b0;
        #1;
        check("R1 reset bus_q", bus_q, '0);
        check("R1 reset viol_sticky", DW'(viol_sticky), '0);
        @(negedge clk);
        check("R1 reset held bus_q", bus_q, '0);
        rst = 1'b0;
        exp_bus = '0; exp_sticky = '0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NS; i++) words[i] = 64'h0101_0101_0101_0101 << i;
        pack_words();
        repeat (3) @(negedge clk);
        do_reset();

        // R2/R11: each single source of group 0 in turn
        for (int i = 0; i < GS; i++) apply(NS'(1) << i, 4'b0000, 1'b0, "R2 one-hot g0");
        // R3: no enables, bus held
        apply('0, 4'b0000, 1'b0, "R3 idle hold");
        apply('0, 4'b0000, 1'b1, "R3 idle hold chk");
        // R2/R6: two-hot in group 0 under at-most-one
        apply(6'b000011, 4'b0101, 1'b1, "R6 two-hot g0");
        // R10: sticky stays set with clean traffic
        apply(6'b000100, 4'b0101, 1'b1, "R10 sticky holds");
        // R4: both groups active, group 0 wins
        apply(6'b101001, 4'b0000, 1'b0, "R4 g0 beats g1");
        // R5: only group 1, two-hot, OR result
        apply(6'b110000, 4'b0000, 1'b0, "R5 g1 two-hot");
        apply(6'b001000, 4'b0000, 1'b0, "R5 g1 one-hot");

        do_reset();
        // R7: none hot under at-least-one, both groups
        apply('0, 4'b1010, 1'b1, "R7 none hot");
        apply(6'b010001, 4'b1010, 1'b1, "R7 each has one");
        do_reset();
        // R8: exactly-one
        apply(6'b100010, 4'b1111, 1'b1, "R8 exact ok");
        apply(6'b000000, 4'b1111, 1'b1, "R8 exact zero");
        apply(6'b111111, 4'b1111, 1'b1, "R8 exact three");
        do_reset();
        // R9: mode off, and chk_en low, with illegal codes
        apply(6'b111111, 4'b0000, 1'b1, "R9 mode off");
        apply(6'b011011, 4'b0101, 1'b0, "R9 chk_en low");
        // R11: only group 1 checked; group 1 violation while group 0 wins bus
        apply(6'b011011, 4'b0100, 1'b1, "R11 g1 mode only");
        apply(6'b011011, 4'b0001, 1'b1, "R11 g0 mode only");

        // Mixed random traffic with changing data
        do_reset();
        for (int k = 0; k < 300; k++) begin
            logic [NS-1:0] pats [10];
            pats = '{6'b000001, 6'b000010, 6'b000100, 6'b001000, 6'b010000,
                     6'b100000, 6'b000000, 6'b000011, 6'b011000, 6'b100101};
            if (k % 7 == 0) begin
                for (int i = 0; i < NS; i++) words[i] = {$urandom, $urandom};
            end
            apply(pats[$urandom_range(0, 9)], 4'($urandom), 1'($urandom), "R2 R4 R6 R10 random");
        end

        @(negedge clk);
        src_en = '0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule